// File: doc/BRIEF.md
# Streaming Running Max/Min Line Filter

This block filters a stream of pixels one line at a time. For every accepted sample it emits the largest value, or in the other mode the smallest, over the last `k` samples of the same line. The window length `k` and the mode are chosen per line. It serves as the row pass of a separable two-dimensional rectangular max/min filter. The column pass and its line storage sit outside this block.

The cost per sample does not depend on `k`. The line is cut into segments of `k` samples. A forward partial extremum `g` restarts at each segment start. A backward partial extremum `h` is formed by reading each finished segment back in reverse order while the next segment arrives. Each output needs one comparison, between `g` at the window's last sample and `h` at its first sample.

The buffers are three ping-pong pairs, each `k` deep: raw samples, `g` and `h`. A window that reaches past the start of the line treats the missing positions as the identity value, 0 for max and all ones for min. After the last sample of a line the block clocks itself for `k+1` more steps to empty its pipeline.

Top module: `runext_line_filter`

## Requirements
- R1: While reset is held, and afterwards until a line is fed, `out_valid` and `out_eol` are low.
- R2: With `cfg_min`=0, the output for sample x of a line is the maximum of samples x-k+1..x of that line. Positions before the line start count as 0.
- R3: With `cfg_min`=1, the output for sample x is the minimum of samples x-k+1..x. Positions before the line start count as all ones.
- R4: Each accepted sample yields exactly one output, in arrival order. `out_eol` is high on, and only on, the output that belongs to the sample accepted with `in_eol`=1. The cycle after it always has `out_valid` low.
- R5: With k=1 the output sequence equals the input sequence.
- R6: When k is at least the line length, every output is the running extremum from the start of the line.
- R7: On a line with no idle cycles, the output for a sample appears k+1 clock edges after the edge that accepts it. This holds through the end-of-line drain.
- R8: Idle cycles (`in_valid`=0) inside a line stall the filter without changing any result.
- R9: `cfg_len` and `cfg_min` are sampled with the first sample of a line. Changes to them later in the line have no effect on that line's outputs.
- R10: A new line may start k+1 cycles after the end-of-line sample. No state carries over from the previous line.
- R11: Window lengths 1..255 and lines of 1..1024 samples are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 8 | Window length k, 1..255, sampled at line start |
| cfg_min | input | 1 | 0 selects running maximum, 1 selects running minimum |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | 8 | Unsigned input sample |
| in_eol | input | 1 | Marks the last sample of the line (qualified by in_valid) |
| out_valid | output | 1 | Output sample present this cycle |
| out_data | output | 8 | Windowed maximum or minimum |
| out_eol | output | 1 | Marks the output belonging to the last sample of the line |

## Verification
The assertions take three things for granted about the inputs. `cfg_len` lies in 1..255 whenever a line begins. `in_valid` stays low during the `k+1` cycles after an end-of-line sample. Every line is closed by `in_eol` within 1024 samples. The stimulus keeps to this: it draws window lengths only from that range, waits exactly `k+1` idle cycles (or more) after each end-of-line sample, and never exceeds the line bound. Its reference treats out-of-line positions as the identity value, which never wins a comparison against a real sample.

// File: rtl/rle_pkg.sv
package rle_pkg;

  // Line phase of the sequencer: waiting, accepting samples, self-clocked drain
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LINE  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

endpackage

// File: rtl/seg_bank.sv
// Ping-pong pair of segment buffers, asynchronous read (distributed storage).
module seg_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 255,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wsel,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rsel,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] half_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_half
    logic [W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wsel == 1'(b))) mem[waddr] <= wdata;
    end
    assign half_rd[b] = mem[raddr];
  end

  assign rdata = half_rd[rsel];

  // R11
  waddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/win_sequencer.sv
// Segment position counters, line phase and output pacing.
module win_sequencer
  import rle_pkg::*;
#(
  parameter int KMAX = 255,
  parameter int LMAX = 1024,
  parameter int KW   = 8,
  parameter int LW   = 11,
  parameter int TW   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] cfg_len,
  input  logic          cfg_min,
  input  logic          in_valid,
  input  logic          in_eol,
  output logic          tick,
  output logic          smp,
  output logic          busy,
  output logic [KW-1:0] k_use,
  output logic          min_use,
  output logic [KW-1:0] in_pos,
  output logic          in_par,
  output logic [KW-1:0] x_pos,
  output logic          x_par,
  output logic          x_first,
  output logic          emit,
  output logic          last
);

  phase_e        ph;
  logic [KW-1:0] k_q;
  logic          min_q;
  logic [TW-1:0] tcnt;
  logic [LW-1:0] n_in;
  logic [LW-1:0] x_cnt;
  logic          in_wrap;
  logic          x_wrap;

  function automatic logic seg_end(input logic [KW-1:0] p, input logic [KW-1:0] k);
    return p == (k - KW'(1));
  endfunction

  assign busy    = (ph != PH_IDLE);
  assign k_use   = busy ? k_q : cfg_len;
  assign min_use = busy ? min_q : cfg_min;
  assign tick    = (ph == PH_DRAIN) ? 1'b1 : in_valid;
  assign smp     = (ph != PH_DRAIN) && in_valid;
  assign in_wrap = seg_end(in_pos, k_use);
  assign x_wrap  = seg_end(x_pos, k_use);
  assign emit    = tick && (tcnt > TW'(k_use)) && (x_cnt < n_in);
  assign last    = emit && (ph == PH_DRAIN) && (x_cnt == n_in - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      k_q     <= '0;
      min_q   <= 1'b0;
      in_pos  <= '0;
      in_par  <= 1'b0;
      tcnt    <= '0;
      n_in    <= '0;
      x_pos   <= '0;
      x_par   <= 1'b0;
      x_first <= 1'b1;
      x_cnt   <= '0;
    end else if (last) begin
      ph      <= PH_IDLE;
      in_pos  <= '0;
      in_par  <= 1'b0;
      tcnt    <= '0;
      n_in    <= '0;
      x_pos   <= '0;
      x_par   <= 1'b0;
      x_first <= 1'b1;
      x_cnt   <= '0;
    end else if (tick) begin
      if (ph == PH_IDLE) begin
        k_q   <= cfg_len;
        min_q <= cfg_min;
      end
      if (smp && in_eol)       ph <= PH_DRAIN;
      else if (ph == PH_IDLE)  ph <= PH_LINE;
      in_pos <= in_wrap ? '0 : in_pos + KW'(1);
      in_par <= in_par ^ in_wrap;
      tcnt   <= tcnt + TW'(1);
      n_in   <= n_in + LW'(smp);
      if (emit) begin
        x_pos <= x_wrap ? '0 : x_pos + KW'(1);
        x_par <= x_par ^ x_wrap;
        if (x_wrap) x_first <= 1'b0;
        x_cnt <= x_cnt + LW'(1);
      end
    end
  end

  // R10
  no_input_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DRAIN) |-> !in_valid);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(k_q) && $stable(min_q)));

  // R4
  out_behind_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_cnt <= n_in);

  // R11
  cfg_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid) |-> (cfg_len != '0 && int'(cfg_len) <= KMAX));

  // R11
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (in_pos < k_q && x_pos < k_q));

  // R11
  line_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(n_in) <= LMAX);

endmodule

// File: rtl/runext_line_filter.sv
// One-dimensional running max/min over a trailing window of k samples,
// forward/backward segment extrema with one comparison per output.
module runext_line_filter #(
  parameter int DW   = 8,
  parameter int KMAX = 255,
  parameter int LMAX = 1024,
  localparam int KW  = $clog2(KMAX + 1),
  localparam int LW  = $clog2(LMAX + 1),
  localparam int TW  = $clog2(LMAX + KMAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] cfg_len,
  input  logic          cfg_min,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_eol,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_eol
);

  function automatic logic [DW-1:0] pad_value(input logic mn);
    return mn ? '1 : '0;
  endfunction

  function automatic logic [DW-1:0] dominant(input logic [DW-1:0] a,
                                             input logic [DW-1:0] b,
                                             input logic mn);
    if (mn) return (a < b) ? a : b;
    return (a > b) ? a : b;
  endfunction

  logic          tick, smp, busy, min_use, in_par, x_par, x_first, emit, last;
  logic [KW-1:0] k_use, in_pos, x_pos;

  win_sequencer #(
    .KMAX(KMAX), .LMAX(LMAX), .KW(KW), .LW(LW), .TW(TW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_min(cfg_min),
    .in_valid(in_valid), .in_eol(in_eol),
    .tick(tick), .smp(smp), .busy(busy), .k_use(k_use), .min_use(min_use),
    .in_pos(in_pos), .in_par(in_par), .x_pos(x_pos), .x_par(x_par),
    .x_first(x_first), .emit(emit), .last(last)
  );

  // Ingest: padded sample and forward extremum g
  logic [DW-1:0] d_in, g_prev, g_cur;
  assign d_in  = smp ? in_data : pad_value(min_use);
  assign g_cur = (in_pos == '0) ? d_in : dominant(g_prev, d_in, min_use);

  // Reverse scan of the previous segment: backward extremum h
  logic [KW-1:0] rev_addr;
  logic [DW-1:0] rev_data, h_prev, h_cur;
  assign rev_addr = k_use - KW'(1) - in_pos;
  assign h_cur    = (in_pos == '0) ? rev_data : dominant(h_prev, rev_data, min_use);

  // Output side: g at window end (x), h at window start (y = x-k+1)
  logic          x_wrap, h_ok, y_par;
  logic [KW-1:0] y_pos;
  logic [DW-1:0] g_rd, h_rd, h_use, r_val;
  assign x_wrap = (x_pos == k_use - KW'(1));
  assign y_pos  = x_wrap ? '0 : x_pos + KW'(1);
  assign y_par  = x_wrap ? x_par : !x_par;
  assign h_ok   = !(x_first && !x_wrap);
  assign h_use  = h_ok ? h_rd : pad_value(min_use);
  assign r_val  = dominant(g_rd, h_use, min_use);

  seg_bank #(.W(DW), .DEPTH(KMAX), .AW(KW)) u_raw (
    .clk(clk), .rst_n(rst_n), .we(tick), .wsel(in_par), .waddr(in_pos),
    .wdata(d_in), .rsel(!in_par), .raddr(rev_addr), .rdata(rev_data)
  );

  seg_bank #(.W(DW), .DEPTH(KMAX), .AW(KW)) u_fwd (
    .clk(clk), .rst_n(rst_n), .we(tick), .wsel(in_par), .waddr(in_pos),
    .wdata(g_cur), .rsel(x_par), .raddr(x_pos), .rdata(g_rd)
  );

  seg_bank #(.W(DW), .DEPTH(KMAX), .AW(KW)) u_bwd (
    .clk(clk), .rst_n(rst_n), .we(tick), .wsel(!in_par), .waddr(rev_addr),
    .wdata(h_cur), .rsel(y_par), .raddr(y_pos), .rdata(h_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_prev    <= '0;
      h_prev    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eol   <= 1'b0;
    end else begin
      if (tick) begin
        g_prev <= g_cur;
        h_prev <= h_cur;
      end
      out_valid <= emit;
      out_eol   <= last;
      if (emit) out_data <= r_val;
    end
  end

  // R4
  eol_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);

  // R4
  eol_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |=> !out_valid);

  // R1
  out_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));

  // R7
  drain_self_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !smp && $past(smp && in_eol)) |-> tick);

endmodule

// File: tb/runext_line_filter_tb.sv
module runext_line_filter_tb;
  localparam int DW = 8;
  localparam int KMAX = 255;
  localparam int LMAX = 1024;
  localparam int KW = $clog2(KMAX + 1);
  localparam int TOP = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [KW-1:0] cfg_len = '0;
  logic cfg_min = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_eol = 1'b0;
  logic out_valid;
  logic [DW-1:0] out_data;
  logic out_eol;

  always #10 clk = ~clk;

  runext_line_filter #(.DW(DW), .KMAX(KMAX), .LMAX(LMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_min(cfg_min),
    .in_valid(in_valid), .in_data(in_data), .in_eol(in_eol),
    .out_valid(out_valid), .out_data(out_data), .out_eol(out_eol)
  );

  typedef struct {
    int val;
    int eol;
    int acc;
    int timed;
    int k;
  } exp_t;

  exp_t  expq[$];
  string reqq[$];
  int    hist[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    n_sent = 0;
  int    n_seen = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Brute-force window reference; out-of-line positions are identity and never win
  function automatic int ref_ext(input int k, input bit mn, input int i);
    int r = mn ? TOP : 0;
    for (int j = i - k + 1; j <= i; j++) begin
      if (j >= 0) begin
        if (mn ? (hist[j] < r) : (hist[j] > r)) r = hist[j];
      end
    end
    return r;
  endfunction

  function automatic int gen(input int pat, input int i);
    case (pat)
      1: return (200 - 3 * i) & TOP;
      2: return (5 * i) & TOP;
      3: return (i % 17 == 0) ? 250 : 10 + (i % 5);
      default: return $urandom_range(0, TOP);
    endcase
  endfunction

  // Output monitor, compared on every clock
  always @(negedge clk) begin : mon
    exp_t e;
    string rq;
    if (rst_n && out_valid) begin
      n_seen++;
      if (expq.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R4 unexpected output: actual %0d expected none", out_data);
      end else begin
        e  = expq.pop_front();
        rq = reqq.pop_front();
        check(rq, "data", int'(out_data), e.val);
        check("R4", "eol", int'(out_eol), e.eol);
        if (e.timed != 0) check("R7", "latency", cyc - e.acc, e.k + 1);
      end
    end
  end

  task automatic send_line(input string req, input int k, input bit mn, input int len,
                           input int pat, input int gap_pct, input int extra_idle,
                           input bit chg_cfg);
    int v;
    exp_t e;
    cfg_len = KW'(k);
    cfg_min = mn;
    hist.delete();
    for (int i = 0; i < len; i++) begin
      if (gap_pct > 0) begin
        while ($urandom_range(0, 99) < gap_pct) begin
          in_valid = 1'b0;
          in_eol   = 1'b0;
          @(negedge clk);
        end
      end
      v = gen(pat, i);
      in_valid = 1'b1;
      in_data  = DW'(v);
      in_eol   = (i == len - 1);
      hist.push_back(v);
      e.val   = ref_ext(k, mn, i);
      e.eol   = (i == len - 1) ? 1 : 0;
      e.acc   = cyc + 1;
      e.timed = (gap_pct == 0) ? 1 : 0;
      e.k     = k;
      expq.push_back(e);
      reqq.push_back(req);
      n_sent++;
      if (chg_cfg && i == len / 2) begin
        cfg_len = KW'((k % 200) + 5);
        cfg_min = ~mn;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_eol   = 1'b0;
    repeat (k + 1 + extra_idle) @(negedge clk);
  endtask

  task automatic wait_empty();
    int t = 0;
    while (expq.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check("R4", "pending outputs", expq.size(), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "out_eol in reset", int'(out_eol), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "out_eol after reset", int'(out_eol), 0);

    // R2 max, R3 min, gapless (R7 timed)
    send_line("R2", 3, 1'b0, 20, 0, 0, 2, 1'b0);
    send_line("R2", 6, 1'b0, 33, 1, 0, 2, 1'b0);
    send_line("R3", 5, 1'b1, 37, 0, 0, 2, 1'b0);
    send_line("R3", 4, 1'b1, 29, 2, 0, 2, 1'b0);
    wait_empty();

    // R5 window of one
    send_line("R5", 1, 1'b0, 12, 0, 0, 1, 1'b0);
    send_line("R5", 1, 1'b1, 9, 3, 0, 1, 1'b0);

    // R6 window at least the line length
    send_line("R6", 40, 1'b0, 10, 1, 0, 0, 1'b0);
    send_line("R6", 7, 1'b1, 7, 2, 0, 0, 1'b0);
    send_line("R6", 8, 1'b1, 1, 0, 0, 0, 1'b0);
    wait_empty();

    // R8 idle cycles inside a line
    send_line("R8", 6, 1'b0, 50, 0, 30, 3, 1'b0);
    send_line("R8", 11, 1'b1, 60, 3, 45, 3, 1'b0);

    // R9 configuration changes mid-line
    send_line("R9", 4, 1'b0, 30, 0, 0, 1, 1'b1);
    send_line("R9", 9, 1'b1, 41, 0, 20, 1, 1'b1);
    wait_empty();

    // R10 back-to-back lines at the minimum gap
    send_line("R10", 5, 1'b0, 23, 0, 0, 0, 1'b0);
    send_line("R10", 2, 1'b1, 15, 0, 0, 0, 1'b0);
    send_line("R10", 9, 1'b0, 4, 3, 0, 0, 1'b0);
    send_line("R10", 3, 1'b1, 18, 0, 0, 0, 1'b0);
    wait_empty();

    // R11 bounds
    send_line("R11", 255, 1'b0, 1024, 0, 0, 1, 1'b0);
    send_line("R11", 200, 1'b1, 1024, 3, 0, 1, 1'b0);
    send_line("R11", 255, 1'b1, 300, 1, 5, 1, 1'b0);
    wait_empty();

    // Mixed random lines
    for (int n = 0; n < 8; n++) begin
      bit mn = 1'($urandom_range(0, 1));
      send_line(mn ? "R3" : "R2", $urandom_range(1, 64), mn, $urandom_range(1, 120),
                0, $urandom_range(0, 1) * 25, $urandom_range(0, 3), 1'b0);
    end
    wait_empty();

    repeat (5) @(negedge clk);
    check("R4", "total outputs", n_seen, n_sent);
    check("R1", "idle after last line", int'(out_valid), 0);
    finish_run();
  end

endmodule